// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit settles, for a processor with fixed four-byte instructions, whether a control-transfer instruction redirects the program and where the next instruction comes from. It accepts three ways of expressing a branch condition, chosen by a 4-bit branch kind. The first tests a set of arithmetic status flags that earlier arithmetic, compare or test instructions left behind. The second tests a general register into which an earlier compare wrote its result. The third compares two register operands inside the branch itself. A fourth kind jumps unconditionally, and a null kind always falls through.

Every destination is relative to the current PC and counted in instructions. A signed offset, sign-extended and scaled by four, is added to the address of the following instruction. The unit registers its inputs on each clock edge. During the next cycle it derives the taken decision and the next PC combinationally from those registered values, so results appear one cycle after they are presented. Fetch, pipeline flushing and prediction sit outside the block.

Top module: `bcu_top`

## Requirements
- R1: A clock edge with `rst_n` low clears the captured state. After that edge, `taken_o` is 0 and `next_pc_o` is 4, whatever the inputs are.
- R2: The outputs depend only on the inputs sampled at the most recent rising clock edge. They stay stable between edges and take the new values one edge after the inputs change.
- R3: The branch target is PC + 4 + (sign-extended `offset_i` × 4), computed modulo 2^XLEN. It wraps through zero in both directions.
- R4: When the branch is not taken, `next_pc_o` is the sampled PC + 4. When it is taken, `next_pc_o` is the target.
- R5: Kind 1 (jump) is always taken. Kind 0 (none) is never taken.
- R6: The flags input is laid out as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. Kind 2 is taken when Z=1. Kind 3 is taken when Z=0.
- R7: The signed flag kinds are: kind 4 (less), taken when N≠V; kind 5 (greater or equal), taken when N=V; kind 6 (greater), taken when Z=0 and N=V; kind 7 (less or equal), taken when Z=1 or N≠V.
- R8: The unsigned flag kinds treat C as "no borrow". Kind 8 (lower) is taken when C=0. Kind 9 (higher or same) is taken when C=1.
- R9: For the compare-result register style, kind 10 is taken when operand A is nonzero and kind 11 is taken when operand A is zero. Operand B is ignored.
- R10: For compare-and-branch, kind 12 is taken when A equals B over all XLEN bits. Kind 13 is taken when they differ.
- R11: For compare-and-branch, kind 14 is taken when A < B as two's-complement values, and kind 15 when A ≥ B. Both are correct at the most negative and most positive values.
- R12: The full offset range is honoured. The largest positive offset reaches +2^(OFF_W-1)-1 instructions, and the most negative reaches -2^(OFF_W-1) instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | XLEN | Address of the branch instruction |
| offset_i | input | OFF_W | Signed offset, counted in instructions |
| kind_i | input | 4 | Branch kind (see R5 to R11) |
| flags_i | input | 4 | Status flags N,Z,C,V in bits 3..0 |
| opa_i | input | XLEN | Register operand A |
| opb_i | input | XLEN | Register operand B |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | XLEN | Address of the next instruction |

## Verification
The unit keeps no history beyond one input register stage. A corrupted captured kind, flag, operand or offset therefore shows up on `taken_o` or `next_pc_o` in the very cycle after the bad edge, and it clears at the following edge once fresh inputs are captured. A wrong condition decode shows as a flipped `taken_o`, paired with `next_pc_o` jumping between PC+4 and the target. A wrong sign extension or scaling in the adder shows only on taken branches, as a target off by a power of two, or as one that fails to wrap at the offset extremes. For that reason the stimulus drives both signs of every comparison and both ends of the offset field.

// File: rtl/bcu_pkg.sv
// Shared definitions for the branch condition and target unit.
// Assumes four-byte instructions; kind codes are fixed because the decoder
// upstream produces them.
package bcu_pkg;

    // Branch kind as delivered by the decoder.
    typedef enum logic [3:0] {
        BK_NONE  = 4'd0,
        BK_JUMP  = 4'd1,
        BK_F_EQ  = 4'd2,
        BK_F_NE  = 4'd3,
        BK_F_LT  = 4'd4,
        BK_F_GE  = 4'd5,
        BK_F_GT  = 4'd6,
        BK_F_LE  = 4'd7,
        BK_F_LO  = 4'd8,
        BK_F_HS  = 4'd9,
        BK_R_NZ  = 4'd10,
        BK_R_Z   = 4'd11,
        BK_C_EQ  = 4'd12,
        BK_C_NE  = 4'd13,
        BK_C_LT  = 4'd14,
        BK_C_GE  = 4'd15
    } br_kind_e;

    // Bit positions inside the status-flag vector.
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

endpackage

// File: rtl/bcu_flag_eval.sv
// Status-flag condition evaluator.
// Decides the branch outcome for the flag-testing kinds; yields 0 for every
// other kind. Assumes the flags come from a subtract-style compare, with C
// meaning "no borrow".
module bcu_flag_eval
    import bcu_pkg::*;
(
    input  br_kind_e   kind,
    input  logic [3:0] flags,
    output logic       hit
);

    logic f_n, f_z, f_c, f_v, sgn_lt;

    // Unpack the flags and form the signed-less relation N xor V.
    always_comb begin
        f_n    = flags[FLG_N];
        f_z    = flags[FLG_Z];
        f_c    = flags[FLG_C];
        f_v    = flags[FLG_V];
        sgn_lt = f_n ^ f_v;
    end

    // Select the condition that the kind asks for.
    always_comb begin
        unique case (kind)
            BK_F_EQ: hit = f_z;
            BK_F_NE: hit = !f_z;
            BK_F_LT: hit = sgn_lt;
            BK_F_GE: hit = !sgn_lt;
            BK_F_GT: hit = !f_z && !sgn_lt;
            BK_F_LE: hit = f_z || sgn_lt;
            BK_F_LO: hit = !f_c;
            BK_F_HS: hit = f_c;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_reg_cmp.sv
// Register-operand condition evaluator.
// Covers the compare-result-register kinds (test A against zero) and the
// fused compare-and-branch kinds (A against B); yields 0 for all other kinds.
// Signed order comes from an XLEN+1 bit subtraction, so it never overflows.
module bcu_reg_cmp
    import bcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic              hit
);

    localparam int DW = XLEN + 1;

    logic [DW-1:0] diff;
    logic          a_zero, a_eq_b, a_lt_b;

    // Sign-extended subtraction; its top bit is the signed less-than result.
    always_comb begin
        diff   = {opa[XLEN-1], opa} - {opb[XLEN-1], opb};
        a_lt_b = diff[DW-1];
        a_eq_b = (opa == opb);
        a_zero = (opa == '0);
    end

    // Select the condition that the kind asks for.
    always_comb begin
        unique case (kind)
            BK_R_NZ: hit = !a_zero;
            BK_R_Z:  hit = a_zero;
            BK_C_EQ: hit = a_eq_b;
            BK_C_NE: hit = !a_eq_b;
            BK_C_LT: hit = a_lt_b;
            BK_C_GE: hit = !a_lt_b;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcu_target.sv
// PC-relative address generator.
// Produces the fall-through address and the branch target, both modulo
// 2^XLEN. Assumes OFF_W < XLEN and instructions of 2^ILEN_LOG2 bytes.
module bcu_target #(
    parameter int XLEN      = 32,
    parameter int OFF_W     = 12,
    parameter int ILEN_LOG2 = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  fall_pc,
    output logic [XLEN-1:0]  tgt_pc
);

    localparam int              EXT_W = XLEN - OFF_W;
    localparam logic [XLEN-1:0] STEP  = XLEN'(1) << ILEN_LOG2;

    logic [XLEN-1:0] off_sx, off_bytes;

    // Widen the instruction offset and scale it to bytes.
    always_comb begin
        off_sx    = {{EXT_W{offset[OFF_W-1]}}, offset};
        off_bytes = off_sx << ILEN_LOG2;
    end

    // The next sequential instruction, and the target relative to it.
    always_comb begin
        fall_pc = pc + STEP;
        tgt_pc  = fall_pc + off_bytes;
    end

endmodule

// File: rtl/bcu_top.sv
// Branch condition and target unit, top level.
// Captures the branch inputs on each rising edge and derives the taken
// decision and the next PC from the captured values within the next cycle.
// Reset is synchronous and active low.
module bcu_top
    import bcu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int OFF_W     = 12,
    parameter int ILEN_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [3:0]       kind_i,
    input  logic [3:0]       flags_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic             taken_o,
    output logic [XLEN-1:0]  next_pc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ILEN_LOG2;

    logic [XLEN-1:0]  pc_q, opa_q, opb_q;
    logic [OFF_W-1:0] off_q;
    br_kind_e         kind_q;
    logic [3:0]       flags_q;

    logic             flag_hit, reg_hit, jump_hit;
    logic [XLEN-1:0]  fall_pc, tgt_pc;

    // Input capture stage; reset returns to a null branch at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            off_q   <= '0;
            kind_q  <= BK_NONE;
            flags_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
        end else begin
            pc_q    <= pc_i;
            off_q   <= offset_i;
            kind_q  <= br_kind_e'(kind_i);
            flags_q <= flags_i;
            opa_q   <= opa_i;
            opb_q   <= opb_i;
        end
    end

    bcu_flag_eval u_flag (
        .kind  (kind_q),
        .flags (flags_q),
        .hit   (flag_hit)
    );

    bcu_reg_cmp #(.XLEN(XLEN)) u_cmp (
        .kind (kind_q),
        .opa  (opa_q),
        .opb  (opb_q),
        .hit  (reg_hit)
    );

    bcu_target #(.XLEN(XLEN), .OFF_W(OFF_W), .ILEN_LOG2(ILEN_LOG2)) u_tgt (
        .pc      (pc_q),
        .offset  (off_q),
        .fall_pc (fall_pc),
        .tgt_pc  (tgt_pc)
    );

    // Merge the condition sources and pick the next address.
    always_comb begin
        jump_hit  = (kind_q == BK_JUMP);
        taken_o   = jump_hit | flag_hit | reg_hit;
        next_pc_o = taken_o ? tgt_pc : fall_pc;
    end

    // ---------------- assertions ----------------
    logic chk_armed;

    // Marks cycles where $past refers to a post-reset sample.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    logic [XLEN-1:0] chk_off_bytes;

    // Independent byte offset used by the target check.
    always_comb
        chk_off_bytes = XLEN'($signed(offset_i)) * STEP;

    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!taken_o && next_pc_o == STEP))
        else $error("R1 reset state");

    p_jump_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(kind_i) == BK_JUMP) |-> taken_o)
        else $error("R5 jump not taken");

    p_none_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(kind_i) == BK_NONE) |-> !taken_o)
        else $error("R5 null kind taken");

    p_fall_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !taken_o) |-> next_pc_o == $past(pc_i) + STEP)
        else $error("R4 fall-through address");

    p_target_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && taken_o) |->
            next_pc_o == $past(pc_i) + STEP + $past(chk_off_bytes))
        else $error("R3 target address");

    p_cmp_eq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(kind_i) == BK_C_EQ) |->
            taken_o == ($past(opa_i) == $past(opb_i)))
        else $error("R10 compare equal");

endmodule

// File: tb/tb_bcu_top.sv
module tb_bcu_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 32;
    localparam int OFF_W = 12;
    localparam int VW    = 4 + 4 + 4 + 1 + XLEN + OFF_W + XLEN + XLEN;
    localparam int NV    = 27;

    // Vector fields: {req, kind, flags NZCV, exp_taken, pc, offset, opa, opb}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd5,  4'd1,  4'b0000, 1'b1, 32'h0000_1000, 12'h010, 32'h0, 32'h0},          // R5 jump
        {4'd5,  4'd0,  4'b0100, 1'b0, 32'h0000_2000, 12'h010, 32'h0, 32'h0},          // R5 none
        {4'd6,  4'd2,  4'b0100, 1'b1, 32'h0000_3000, 12'h004, 32'h0, 32'h0},          // R6 eq Z=1
        {4'd6,  4'd2,  4'b0000, 1'b0, 32'h0000_3000, 12'h004, 32'h0, 32'h0},          // R6 eq Z=0
        {4'd6,  4'd3,  4'b0000, 1'b1, 32'h0000_3000, 12'hFFC, 32'h0, 32'h0},          // R6 ne
        {4'd7,  4'd4,  4'b1000, 1'b1, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 lt N!=V
        {4'd7,  4'd4,  4'b1001, 1'b0, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 lt N=V
        {4'd7,  4'd5,  4'b0001, 1'b0, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 ge
        {4'd7,  4'd6,  4'b1001, 1'b1, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 gt
        {4'd7,  4'd6,  4'b0100, 1'b0, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 gt Z=1
        {4'd7,  4'd7,  4'b0100, 1'b1, 32'h0000_4000, 12'h020, 32'h0, 32'h0},          // R7 le
        {4'd8,  4'd8,  4'b0000, 1'b1, 32'h0000_5000, 12'h001, 32'h0, 32'h0},          // R8 lo C=0
        {4'd8,  4'd9,  4'b0010, 1'b1, 32'h0000_5000, 12'h001, 32'h0, 32'h0},          // R8 hs C=1
        {4'd8,  4'd8,  4'b0010, 1'b0, 32'h0000_5000, 12'h001, 32'h0, 32'h0},          // R8 lo C=1
        {4'd9,  4'd10, 4'b0000, 1'b1, 32'h0000_6000, 12'h008, 32'h8000_0000, 32'h0},  // R9 nz
        {4'd9,  4'd10, 4'b0100, 1'b0, 32'h0000_6000, 12'h008, 32'h0, 32'hFFFF_FFFF}, // R9 nz on 0
        {4'd9,  4'd11, 4'b0000, 1'b1, 32'h0000_6000, 12'h008, 32'h0, 32'h1234_5678}, // R9 z
        {4'd10, 4'd12, 4'b0000, 1'b1, 32'h0000_7000, 12'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R10
        {4'd10, 4'd13, 4'b0100, 1'b1, 32'h0000_7000, 12'h100, 32'h1, 32'h2},         // R10 ne
        {4'd10, 4'd12, 4'b0100, 1'b0, 32'h0000_7000, 12'h100, 32'h1, 32'h8000_0001}, // R10 msb
        {4'd11, 4'd14, 4'b0000, 1'b1, 32'h0000_8000, 12'hF00, 32'h8000_0000, 32'h7FFF_FFFF}, // R11
        {4'd11, 4'd14, 4'b1000, 1'b0, 32'h0000_8000, 12'hF00, 32'h7FFF_FFFF, 32'h8000_0000}, // R11
        {4'd11, 4'd15, 4'b0000, 1'b1, 32'h0000_8000, 12'hF00, 32'h5, 32'h5},         // R11 ge eq
        {4'd11, 4'd14, 4'b0000, 1'b1, 32'h0000_8000, 12'hF00, 32'hFFFF_FFFF, 32'h0}, // R11 -1<0
        {4'd12, 4'd1,  4'b0000, 1'b1, 32'h0000_0000, 12'h7FF, 32'h0, 32'h0},          // R12 max
        {4'd12, 4'd1,  4'b0000, 1'b1, 32'h0001_0000, 12'h800, 32'h0, 32'h0},          // R12 min
        {4'd3,  4'd1,  4'b0000, 1'b1, 32'h0000_0000, 12'h800, 32'h0, 32'h0}           // R3 wrap
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [XLEN-1:0]  pc_i = '0;
    logic [OFF_W-1:0] offset_i = '0;
    logic [3:0]       kind_i = '0;
    logic [3:0]       flags_i = '0;
    logic [XLEN-1:0]  opa_i = '0;
    logic [XLEN-1:0]  opb_i = '0;
    logic             taken_o;
    logic [XLEN-1:0]  next_pc_o;

    int n_run = 0;
    int n_fail = 0;

    bcu_top #(.XLEN(XLEN), .OFF_W(OFF_W), .ILEN_LOG2(2)) dut (
        .clk, .rst_n, .pc_i, .offset_i, .kind_i, .flags_i,
        .opa_i, .opb_i, .taken_o, .next_pc_o
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [XLEN-1:0] exp_pc(input logic [XLEN-1:0] pc,
                                               input logic [OFF_W-1:0] off,
                                               input logic tk);
        logic signed [XLEN-1:0] soff;
        soff = XLEN'($signed(off));
        return tk ? pc + 32'd4 + (soff * 4) : pc + 32'd4;
    endfunction

    task automatic check(input string req, input logic tk, input logic [XLEN-1:0] npc);
        n_run++;
        if (taken_o !== tk || next_pc_o !== npc) begin
            n_fail++;
            $display("FAIL %s: got taken=%0b next_pc=%h, expected taken=%0b next_pc=%h",
                     req, taken_o, next_pc_o, tk, npc);
        end
    endtask

    task automatic drive(input logic [3:0] k, input logic [3:0] f, input logic [XLEN-1:0] pc,
                         input logic [OFF_W-1:0] off, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b);
        @(negedge clk);
        kind_i = k; flags_i = f; pc_i = pc; offset_i = off; opa_i = a; opb_i = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset with a jump presented must still give the reset state.
        kind_i = 4'd1; pc_i = 32'h100; offset_i = 12'h010;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk over all kinds and offsets.
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string rq;
            v = VEC[i];
            drive(v[116:113], v[112:109], v[107:76], v[75:64], v[63:32], v[31:0]);
            rq = $sformatf("R%0d vec%0d", v[120:117], i);
            check(rq, v[108], exp_pc(v[107:76], v[75:64], v[108]));
        end

        // R2: outputs hold until the next edge, then follow the new inputs.
        drive(4'd1, 4'b0000, 32'h0000_9000, 12'h002, '0, '0);
        check("R2 first", 1'b1, 32'h0000_900C);
        @(negedge clk);
        kind_i = 4'd0; pc_i = 32'h0000_A000;
        #1;
        check("R2 hold", 1'b1, 32'h0000_900C);
        @(posedge clk);
        #1;
        check("R2 update", 1'b0, 32'h0000_A004);

        // R4: not-taken flag branch with a nonzero offset falls through.
        drive(4'd2, 4'b1011, 32'hFFFF_FFFC, 12'h7FF, '0, '0);
        check("R4 fall wrap", 1'b0, 32'h0000_0000);

        // R9: operand B has no effect on the register-zero test.
        drive(4'd11, 4'b0000, 32'h0000_B000, 12'h001, 32'h0, 32'hFFFF_FFFF);
        check("R9 B ignored", 1'b1, 32'h0000_B008);

        // R1: mid-run reset clears a pending taken branch.
        @(negedge clk);
        rst_n = 1'b0; kind_i = 4'd1;
        @(posedge clk);
        #1;
        check("R1 mid-run", 1'b0, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule